// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a virtual address by walking a multi-level radix tree held in memory. The caller supplies the address to translate, the base address of the root directory, the root index width and the width of the address space in bits. The walker fetches one 64-bit entry per level over a read port with a request/valid handshake. Each non-leaf entry names the index width and the base address of the next level. The remaining address width shrinks by the index width consumed at every level. The walk stops at an entry marked as a leaf, or at the first fault.

After a successful walk, the block returns four things: the real address, the page size as a bit count, the leaf entry after its update, and the memory address of that entry. It sets the reference bit in the leaf entry, and sets the change bit as well when the access is a store. The entry is written back through a write port only when one of those bits was not already set. A load result carries no write permission, so that a later store takes the walk again and marks the page as changed. A fault is reported as a bit vector of causes.

Top module: `radix_walker`

## Requirements
- R1: After reset, `ready` is 1 and `done`, `rdReq` and `wrEn` are 0.
- R2: The walk ends with fault bit 0 (bad configuration) set, and makes no further read, when the index width of the current level is below 5. This applies both to the root width and to a width taken from a fetched entry.
- R3: The walk ends with fault bit 0 set, and makes no read, when the current index width exceeds the remaining address width.
- R4: The entry read at each level sits at base + 8 × index. The index is (vaddr >> (remaining − width)) masked to `width` bits. `rdReq` stays high with a stable `rdAddr` until `rdValid` is seen.
- R5: A fetched entry whose bit 63 (valid) is 0 ends the walk with fault bit 1 (no entry) set.
- R6: Each valid entry reduces the remaining width by the current index width. A non-leaf entry supplies the next index width in bits [4:0] and the next base address in bits [55:8], with the other bits cleared.
- R7: An entry with bit 62 (leaf) set ends the walk. `pageBits` equals the remaining width. `realAddr` is entry bits [55:12] above `pageBits`, ORed with `vaddr` below `pageBits`.
- R8: The leaf entry gets bit 8 (reference) set, and gets bit 7 (change) set on a store. It is written to `leafAddr` only if its value changed. `leafEntry` shows the updated value.
- R9: `writeOk` is 1 only for a store access.
- R10: At most LEVEL_MAX (8) entries are read in one walk. Needing one more ends the walk with fault bit 0 set.
- R11: `done` is a one-cycle pulse. At most one fault bit is set. A read and a write are never requested in the same cycle.
- R12: A `start` pulse while `ready` is 0 is ignored, and the walk in progress completes with its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted when ready) |
| ready | output | 1 | Walker idle |
| vaddr | input | 64 | Address to translate |
| rootBase | input | 64 | Root directory base address |
| rootSize | input | 5 | Root index width in bits |
| spaceBits | input | 7 | Address-space width in bits (≤ 64) |
| isStore | input | 1 | Access is a store |
| rdReq | output | 1 | Memory read request |
| rdAddr | output | 64 | Memory read address |
| rdValid | input | 1 | Read data valid, completes the request |
| rdData | input | 64 | Read data |
| wrEn | output | 1 | Memory write request |
| wrAddr | output | 64 | Memory write address |
| wrData | output | 64 | Memory write data |
| wrAck | input | 1 | Write accepted |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 2 | Bit 0 bad configuration, bit 1 no entry |
| realAddr | output | 64 | Translated address |
| pageBits | output | 7 | Page size as bit count |
| leafEntry | output | 64 | Updated leaf entry |
| leafAddr | output | 64 | Memory address of the leaf entry |
| writeOk | output | 1 | Result grants write permission |

## Verification
The bench uses directed trees to reach several corner cases, and compares each against its expected outcome:
- An index width below 5 at the root: a design that ignored this would still issue reads.
- An index width below 5 taken from a fetched entry: a design that ignored this would keep indexing with a tiny or empty table.
- A width larger than the remaining address space: a design that ignored this would use a negative shift.
- A self-referencing directory: a design without the level cap would loop forever or read more than eight entries.

Reference and change updates are checked for load and store, on entries that already carry those bits. A design that wrote back unconditionally, or never set the change bit, shows up in the write count and in memory contents.

Random trees with random memory latency are then checked against a bench model of the walk. That model covers the base-field masking, the page-size shrink and the real-address merge.

// File: rtl/radix_walker_pkg.sv
package radix_walker_pkg;
  localparam int ENT_W      = 64;
  localparam int VALID_BIT  = 63;
  localparam int LEAF_BIT   = 62;
  localparam int REF_BIT    = 8;
  localparam int CHG_BIT    = 7;
  localparam int SIZE_W     = 5;
  localparam int MIN_SIZE   = 5;
  localparam logic [ENT_W-1:0] BASE_FIELD = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [ENT_W-1:0] PAGE_FIELD = 64'h00FF_FFFF_FFFF_F000;
  localparam int FAULT_W    = 2;
  localparam int FLT_BADCFG = 0;
  localparam int FLT_NOENT  = 1;

  typedef struct packed {
    logic load;
    logic take;
    logic flagBad;
    logic flagMiss;
  } walkStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ, ST_UPDATE, ST_WRITE, ST_FIN
  } walkState_t;
endpackage

// File: rtl/radix_walker_dp.sv
module radix_walker_dp
  import radix_walker_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int LEVEL_MAX = 8,
  localparam int SPACE_W  = $clog2(ADDR_W + 1),
  localparam int LVL_W    = $clog2(LEVEL_MAX + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobe_t         ctl,
  input  logic [ADDR_W-1:0]   startVaddr,
  input  logic [ADDR_W-1:0]   startRoot,
  input  logic [SIZE_W-1:0]   startSize,
  input  logic [SPACE_W-1:0]  startSpace,
  input  logic                startStore,
  input  logic [ENT_W-1:0]    rdData,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic                entValid,
  output logic                entLeaf,
  output logic                cfgBad,
  output logic                levelFull,
  output logic                entChanged,
  output logic [ENT_W-1:0]    wrData,
  output logic [ADDR_W-1:0]   realAddr,
  output logic [SPACE_W-1:0]  pageBits,
  output logic [ENT_W-1:0]    leafEntry,
  output logic [ADDR_W-1:0]   leafAddr,
  output logic                writeOk,
  output logic [FAULT_W-1:0]  fault
);
  logic [ADDR_W-1:0]  vaReg, baseReg, addrReg;
  logic [SIZE_W-1:0]  sizeReg;
  logic [SPACE_W-1:0] remReg;
  logic [LVL_W-1:0]   lvlReg;
  logic               storeReg;
  logic [ENT_W-1:0]   entReg;
  logic [FAULT_W-1:0] faultReg;

  logic [SPACE_W-1:0] shiftAmt;
  logic [ADDR_W-1:0]  idxMask, index, pgMask;
  logic [ENT_W-1:0]   newEnt;

  always_comb begin
    shiftAmt = remReg - SPACE_W'(sizeReg);
    idxMask  = (ADDR_W'(1) << sizeReg) - ADDR_W'(1);
    index    = (vaReg >> shiftAmt) & idxMask;
    rdAddr   = baseReg + {index[ADDR_W-4:0], 3'b000};
  end

  assign cfgBad    = (sizeReg < SIZE_W'(MIN_SIZE)) || (SPACE_W'(sizeReg) > remReg);
  assign levelFull = (lvlReg == LVL_W'(LEVEL_MAX));
  assign entValid  = rdData[VALID_BIT];
  assign entLeaf   = rdData[LEAF_BIT];

  always_comb begin
    newEnt = entReg;
    newEnt[REF_BIT] = 1'b1;
    if (storeReg) newEnt[CHG_BIT] = 1'b1;
  end
  assign entChanged = (newEnt != entReg);
  assign wrData     = newEnt;

  always_comb begin
    if (remReg >= SPACE_W'(ADDR_W)) pgMask = '1;
    else                            pgMask = (ADDR_W'(1) << remReg) - ADDR_W'(1);
    realAddr = (entReg[ADDR_W-1:0] & PAGE_FIELD[ADDR_W-1:0] & ~pgMask) | (vaReg & pgMask);
  end

  assign pageBits  = remReg;
  assign leafEntry = newEnt;
  assign leafAddr  = addrReg;
  assign writeOk   = storeReg;
  assign fault     = faultReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      baseReg  <= '0;
      addrReg  <= '0;
      sizeReg  <= '0;
      remReg   <= '0;
      lvlReg   <= '0;
      storeReg <= 1'b0;
      entReg   <= '0;
      faultReg <= '0;
    end else begin
      if (ctl.load) begin
        vaReg    <= startVaddr;
        baseReg  <= startRoot;
        sizeReg  <= startSize;
        remReg   <= startSpace;
        storeReg <= startStore;
        lvlReg   <= '0;
        faultReg <= '0;
        entReg   <= '0;
      end
      if (ctl.take) begin
        entReg  <= rdData;
        addrReg <= rdAddr;
        remReg  <= remReg - SPACE_W'(sizeReg);
        lvlReg  <= lvlReg + LVL_W'(1);
        if (!rdData[LEAF_BIT]) begin
          sizeReg <= rdData[SIZE_W-1:0];
          baseReg <= rdData[ADDR_W-1:0] & BASE_FIELD[ADDR_W-1:0];
        end
      end
      if (ctl.flagBad)  faultReg[FLT_BADCFG] <= 1'b1;
      if (ctl.flagMiss) faultReg[FLT_NOENT]  <= 1'b1;
    end
  end

  // R6: every accepted entry consumes width, so remaining never grows between loads
  p_rem_shrinks_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |=> remReg < $past(remReg) || $past(sizeReg) == '0);

  // R10: the level count never passes its cap
  p_level_cap_r10: assert property (@(posedge clk) disable iff (!rstN)
    lvlReg <= LVL_W'(LEVEL_MAX));
endmodule

// File: rtl/radix_walker_ctrl.sv
module radix_walker_ctrl
  import radix_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        entValid,
  input  logic        entLeaf,
  input  logic        cfgBad,
  input  logic        levelFull,
  input  logic        entChanged,
  input  logic        rdValid,
  input  logic        wrAck,
  output walkStrobe_t ctl,
  output logic        rdReq,
  output logic        wrEn,
  output logic        done,
  output logic        ready
);
  walkState_t state, nextState;

  always_comb begin
    nextState = state;
    ctl   = '0;
    rdReq = 1'b0;
    wrEn  = 1'b0;
    done  = 1'b0;
    ready = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ready = 1'b1;
        if (start) begin
          ctl.load  = 1'b1;
          nextState = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (cfgBad || levelFull) begin
          ctl.flagBad = 1'b1;
          nextState   = ST_FIN;
        end else begin
          nextState = ST_READ;
        end
      end
      ST_READ: begin
        rdReq = 1'b1;
        if (rdValid) begin
          if (!entValid) begin
            ctl.flagMiss = 1'b1;
            nextState    = ST_FIN;
          end else begin
            ctl.take  = 1'b1;
            nextState = entLeaf ? ST_UPDATE : ST_CHECK;
          end
        end
      end
      ST_UPDATE: nextState = entChanged ? ST_WRITE : ST_FIN;
      ST_WRITE: begin
        wrEn = 1'b1;
        if (wrAck) nextState = ST_FIN;
      end
      ST_FIN: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R2: once a configuration fault is raised no read follows
  p_no_read_after_bad_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flagBad |=> !rdReq);

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walker_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int LEVEL_MAX = 8,
  localparam int SPACE_W  = $clog2(ADDR_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  output logic                ready,
  input  logic [ADDR_W-1:0]   vaddr,
  input  logic [ADDR_W-1:0]   rootBase,
  input  logic [SIZE_W-1:0]   rootSize,
  input  logic [SPACE_W-1:0]  spaceBits,
  input  logic                isStore,
  output logic                rdReq,
  output logic [ADDR_W-1:0]   rdAddr,
  input  logic                rdValid,
  input  logic [ENT_W-1:0]    rdData,
  output logic                wrEn,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [ENT_W-1:0]    wrData,
  input  logic                wrAck,
  output logic                done,
  output logic [FAULT_W-1:0]  fault,
  output logic [ADDR_W-1:0]   realAddr,
  output logic [SPACE_W-1:0]  pageBits,
  output logic [ENT_W-1:0]    leafEntry,
  output logic [ADDR_W-1:0]   leafAddr,
  output logic                writeOk
);
  walkStrobe_t ctl;
  logic entValid, entLeaf, cfgBad, levelFull, entChanged;

  radix_walker_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .entValid(entValid), .entLeaf(entLeaf), .cfgBad(cfgBad),
    .levelFull(levelFull), .entChanged(entChanged),
    .rdValid(rdValid), .wrAck(wrAck),
    .ctl(ctl), .rdReq(rdReq), .wrEn(wrEn), .done(done), .ready(ready)
  );

  radix_walker_dp #(.ADDR_W(ADDR_W), .LEVEL_MAX(LEVEL_MAX)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .startVaddr(vaddr), .startRoot(rootBase), .startSize(rootSize),
    .startSpace(spaceBits), .startStore(isStore), .rdData(rdData),
    .rdAddr(rdAddr), .entValid(entValid), .entLeaf(entLeaf),
    .cfgBad(cfgBad), .levelFull(levelFull), .entChanged(entChanged),
    .wrData(wrData), .realAddr(realAddr), .pageBits(pageBits),
    .leafEntry(leafEntry), .leafAddr(leafAddr), .writeOk(writeOk),
    .fault(fault)
  );

  assign wrAddr = leafAddr;

  // R4: a pending read keeps its request and address
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdValid |=> rdReq && $stable(rdAddr));

  // R11: one memory transaction at a time
  p_one_txn_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && wrEn));

  // R11: causes never pile up in one walk
  p_fault_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fault));

  // R8: any write-back carries the reference bit
  p_ref_on_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrData[REF_BIT]);

  // R8: a clean finish presents a valid, referenced leaf
  p_leaf_ok_r8: assert property (@(posedge clk) disable iff (!rstN)
    done && fault == '0 |-> leafEntry[VALID_BIT] && leafEntry[LEAF_BIT] && leafEntry[REF_BIT]);
endmodule

// File: tb/test_radix_walker.sv
`timescale 1ns/1ps
module test_radix_walker;
  localparam int LVL = 8;
  localparam logic [63:0] BASEF = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [63:0] PAGEF = 64'h00FF_FFFF_FFFF_F000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic start = 0, isStore = 0, rdValid = 0, wrAck = 0;
  logic [63:0] vaddr = 0, rootBase = 0, rdData = 0;
  logic [4:0] rootSize = 0;
  logic [6:0] spaceBits = 0;
  logic ready, rdReq, wrEn, done, writeOk;
  logic [63:0] rdAddr, wrAddr, wrData, realAddr, leafEntry, leafAddr;
  logic [1:0] fault;
  logic [6:0] pageBits;

  radix_walker i_radix_walker (
    .clk(clk), .rstN(rstN), .start(start), .ready(ready), .vaddr(vaddr),
    .rootBase(rootBase), .rootSize(rootSize), .spaceBits(spaceBits),
    .isStore(isStore), .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrAck(wrAck), .done(done), .fault(fault), .realAddr(realAddr),
    .pageBits(pageBits), .leafEntry(leafEntry), .leafAddr(leafAddr),
    .writeOk(writeOk)
  );

  logic [63:0] mem [0:8191];
  int rdCount = 0, wrCount = 0, rdWait = 0, wrWait = 0;
  int checks = 0, fails = 0;
  logic [63:0] wrAddrL, wrDataL;

  // memory responder: changes only at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        rdValid = 1'b0;
        rdCount++;
      end else if (rdReq) begin
        if (rdWait == 0) begin
          rdValid = 1'b1;
          rdData  = mem[rdAddr[15:3]];
          rdWait  = $urandom % 4;
        end else rdWait--;
      end
      if (wrAck) begin
        wrAck = 1'b0;
        mem[wrAddrL[15:3]] = wrDataL;
        wrCount++;
      end else if (wrEn) begin
        if (wrWait == 0) begin
          wrAck   = 1'b1;
          wrAddrL = wrAddr;
          wrDataL = wrData;
          wrWait  = $urandom % 3;
        end else wrWait--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected walk, computed from the requirements on the bench memory
  function automatic void model(input logic [63:0] va, input logic [63:0] root, input int rs,
                                input int sp, input bit st, output logic [1:0] f,
                                output logic [63:0] ra, output int pg, output logic [63:0] le,
                                output logic [63:0] la, output bit wr, output int reads);
    int rem = sp;
    int sz = rs;
    logic [63:0] base = root;
    logic [63:0] e, a, idx, m;
    f = 0; ra = 0; pg = 0; le = 0; la = 0; wr = 0; reads = 0;
    for (int lv = 0; lv <= LVL; lv++) begin
      if (sz < 5 || sz > rem || lv == LVL) begin f = 2'b01; return; end
      idx = (va >> (rem - sz)) & ((64'd1 << sz) - 64'd1);
      a = base + idx * 8;
      e = mem[a[15:3]];
      reads++;
      if (!e[63]) begin f = 2'b10; return; end
      rem -= sz;
      if (e[62]) begin
        le = e | 64'h100 | (st ? 64'h80 : 64'h0);
        wr = (le != e);
        la = a;
        pg = rem;
        m = (rem >= 64) ? '1 : ((64'd1 << rem) - 64'd1);
        ra = (e & PAGEF & ~m) | (va & m);
        return;
      end
      sz = int'(e[4:0]);
      base = e & BASEF;
    end
  endfunction

  task automatic runWalk(input logic [63:0] va, input logic [63:0] root, input int rs,
                         input int sp, input bit st, input bit poke, input string tag);
    logic [1:0] ef; logic [63:0] era, ele, ela; int epg, ereads; bit ewr;
    int r0, w0, n;
    model(va, root, rs, sp, st, ef, era, epg, ele, ela, ewr, ereads);
    r0 = rdCount; w0 = wrCount;
    @(negedge clk);
    start = 1; vaddr = va; rootBase = root; rootSize = 5'(rs); spaceBits = 7'(sp); isStore = st;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 3000) begin
      if (poke && n == 2) begin
        // R12: a second start while busy with a bad root must be ignored
        start = 1; vaddr = ~va; rootSize = 5'd3; isStore = ~st;
      end else start = 0;
      @(negedge clk);
      n++;
    end
    start = 0;
    chk(done == 1'b1, {"R11 done seen ", tag}, 64'(done), 64'd1);
    chk(fault == ef, {"R2 R3 R5 R10 fault ", tag}, 64'(fault), 64'(ef));
    if (ef == 0) begin
      chk(realAddr == era, {"R7 realAddr ", tag}, realAddr, era);
      chk(int'(pageBits) == epg, {"R6 R7 pageBits ", tag}, 64'(pageBits), 64'(epg));
      chk(leafAddr == ela, {"R4 leafAddr ", tag}, leafAddr, ela);
      chk(leafEntry == ele, {"R8 leafEntry ", tag}, leafEntry, ele);
      chk(writeOk == st, {"R9 writeOk ", tag}, 64'(writeOk), 64'(st));
    end
    @(negedge clk);
    chk(done == 1'b0, {"R11 done pulse ", tag}, 64'(done), 64'd0);
    @(negedge clk);
    chk(rdCount - r0 == ereads, {"R2 R10 read count ", tag}, 64'(rdCount - r0), 64'(ereads));
    chk(wrCount - w0 == ((ef == 0 && ewr) ? 1 : 0), {"R8 write count ", tag},
        64'(wrCount - w0), 64'((ef == 0 && ewr) ? 1 : 0));
    if (ef == 0 && ewr)
      chk(mem[ela[15:3]] == ele, {"R8 memory ", tag}, mem[ela[15:3]], ele);
  endtask

  task automatic clearMem();
    for (int i = 0; i < 8192; i++) mem[i] = 64'h0;
  endtask

  task automatic fillTable(input logic [63:0] base, input int sz, input logic [63:0] ent);
    for (int i = 0; i < (1 << sz); i++) mem[(base[15:3] + 13'(i)) & 13'h1FFF] = ent;
  endtask

  function automatic logic [63:0] dirEnt(input logic [63:0] nb, input int sz);
    return (64'd1 << 63) | (nb & BASEF) | 64'(sz);
  endfunction

  initial begin
    void'($urandom(32'd1234));
    clearMem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready == 1'b1, "R1 ready", 64'(ready), 64'd1);
    chk(done == 1'b0 && rdReq == 1'b0 && wrEn == 1'b0, "R1 idle outputs",
        64'({done, rdReq, wrEn}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    runWalk(64'h1234, 64'h100, 4, 40, 0, 0, "root width 4");
    runWalk(64'h1234, 64'h100, 5, 40, 0, 0, "invalid root entry");
    runWalk(64'h55, 64'h100, 9, 8, 0, 0, "width over space");

    fillTable(64'h1000, 6, dirEnt(64'h4000, 9));
    fillTable(64'h4000, 9, (64'd3 << 62) | 64'h0000_ABCD_EF00_0000 | 64'h100);
    runWalk(64'h0000_A5A5_1234_5678, 64'h1000, 6, 48, 0, 0, "two level load");
    chk(pageBits == 7'd33, "R6 pageBits 48-6-9", 64'(pageBits), 64'd33);
    runWalk(64'h0000_A5A5_1234_5678, 64'h1000, 6, 48, 1, 0, "two level store");
    runWalk(64'h0000_A5A5_1234_5678, 64'h1000, 6, 48, 1, 0, "store already dirty");
    runWalk(64'h0000_1111_2222_3333, 64'h1000, 6, 48, 0, 1, "busy start ignored R12");

    fillTable(64'h1000, 6, dirEnt(64'h4000, 3));
    runWalk(64'h0000_A5A5_1234_5678, 64'h1000, 6, 48, 0, 0, "inner width 3");

    fillTable(64'h2000, 5, dirEnt(64'h2000, 5));
    runWalk(64'h0, 64'h2000, 5, 64, 0, 0, "level cap R10");

    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < 8192; i++) begin
        logic [63:0] e;
        e = {$urandom, $urandom};
        e[63] = ($urandom % 8) != 0;
        e[62] = ($urandom % 3) == 0;
        e[4:0] = 5'(4 + $urandom % 6);
        mem[i] = e;
      end
      runWalk({$urandom, $urandom}, 64'({$urandom % 256, 8'h00}), 3 + $urandom % 8,
              10 + $urandom % 55, 1'($urandom % 2), 0, "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule